// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs the external memory cycles of an 8-bit processor core that has a 16-bit address space. The core hands it one request at a time: a code fetch, a data read or a data write, with an address and, for writes, a data byte. The block plays the request out on a multiplexed bus. The low address byte and the data byte share one port. A latch-enable strobe marks the cycle in which that port holds the address, so an external latch can capture it. The high address byte has a port of its own.

Code fetches, data reads and data writes each use their own active-low strobe. The block also decodes active-low chip selects from the top address bits. A read returns its byte on `rdata` together with a one-cycle `done` pulse.

A code-location input selects where fetches are served. When it is high, fetches below a parameterised internal code size are answered at once and no bus activity takes place. When it is low, every fetch goes to the external bus. The shared port is presented as separate out, in and output-enable signals so that the pad ring can build the bidirectional pin.

Top module: `xbus_seq`

## Requirements
- R1: In the cycle after a request is accepted, `ale` is high, `ad_oe` is high and `ad_out` carries the low address byte. `hi_addr` carries the high address byte.
- R2: For a write, `ad_out` carries the write byte with `ad_oe` high from the cycle after `ale` falls through the cycle after `wr_n` rises. For a fetch or a read, `ad_oe` is low while the strobe is low.
- R3: `hi_addr` does not change from the `ale` cycle to the end of the external cycle.
- R4: The request type selects the strobe: code 0 (fetch) uses `fetch_n`, code 1 (read) uses `rd_n` and code 2 (write) uses `wr_n`. Code 3 is treated as a read. At most one strobe is low at a time, and none is low while `ale` is high.
- R5: Each strobe stays low for exactly STROBE_CYCLES consecutive cycles (default 2). A one-cycle setup gap separates the fall of `ale` from the fall of the strobe.
- R6: For a fetch or a read, `rdata` holds the value on `ad_in` at the clock edge that ends the last strobe cycle, and it is valid while `done` is high.
- R7: `done` is a one-cycle pulse. For an external cycle it is high STROBE_CYCLES+2 cycles after the `ale` cycle, which is the cycle after the strobe rises.
- R8: During an external cycle exactly one chip select `cs_n[i]` is low, where i is address bits 15:13. All chip selects are high otherwise.
- R9: While `code_int_en` is low, every fetch, including one at address 0, runs as an external cycle.
- R10: While `code_int_en` is high, a fetch below INT_CODE_BYTES (default 4096) raises `done` and `int_hit` in the cycle after acceptance, with no `ale`, strobe or chip select. A fetch at or above that address runs externally with `int_hit` low.
- R11: After reset `ale`, `ad_oe`, `done`, `int_hit` and `busy` are low, and all strobes and chip selects are high. A request is accepted only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present (taken while busy is low) |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| code_int_en | input | 1 | High: low code addresses are served internally |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| int_hit | output | 1 | The completed fetch was served internally |
| rdata | output | 8 | Read or fetch result |
| ad_out | output | 8 | Shared port, driven value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | 8 | Shared port, received value |
| hi_addr | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| fetch_n | output | 1 | Code fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| cs_n | output | 8 | Chip selects, active low |

## Verification
The bench sends fetches, reads and writes to addresses that fall in several chip-select regions. These show that each request type picks its own strobe and that the decoder picks the right select. The memory model answers with a byte derived from both address halves, so a wrong low-byte latch or a wrong high byte shows up in `rdata`. Fetches are sent just below and at the internal code boundary with `code_int_en` high, and again at low addresses with it low. These separate the internal path from the external one. Writes with distinct data bytes show whether the port carries the data, rather than the address, through the strobe and into the hold cycle.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus sequencer.
// Assumes: request codes and phase names are used by all submodules.
package xbus_pkg;
    typedef enum logic [1:0] {K_FETCH = 2'd0, K_DRD = 2'd1, K_DWR = 2'd2} kind_t;
    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_SETUP, PH_STRB, PH_HOLD, PH_INT
    } phase_t;
endpackage

// File: rtl/xbus_phase.sv
// Phase sequencer: walks an accepted request through address, setup,
// strobe and hold phases, or a single internal-hit phase.
// Assumes: requests arrive only while the phase is idle.
module xbus_phase
    import xbus_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int STROBE_CYCLES  = 2,
    parameter int INT_CODE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              code_int_en,
    output phase_t            phase,
    output logic              accept,
    output logic              last_strb
);
    localparam int CW = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          hit_int;

    // Decide whether a new fetch is served from internal code memory
    always_comb begin
        hit_int = (req_kind == 2'd0) && code_int_en
                  && (32'(req_addr) < INT_CODE_BYTES);
    end

    assign accept    = req_valid && (phase == PH_IDLE);
    assign last_strb = (phase == PH_STRB) && (cnt == CNT_LAST);

    // Advance the phase and count strobe cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE:  if (accept) phase <= hit_int ? PH_INT : PH_ADDR;
                PH_ADDR:  phase <= PH_SETUP;
                PH_SETUP: begin
                    phase <= PH_STRB;
                    cnt   <= '0;
                end
                PH_STRB:  if (cnt == CNT_LAST) phase <= PH_HOLD;
                          else cnt <= cnt + 1'b1;
                PH_HOLD:  phase <= PH_IDLE;
                PH_INT:   phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xbus_datapath.sv
// Request capture and read return: holds the address, type and write
// byte for the whole cycle, and samples the shared port on the last
// strobe edge.
// Assumes: accept and last_strb come from the phase sequencer.
module xbus_datapath
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              last_strb,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-1:0] lat_addr,
    output kind_t             lat_kind,
    output logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] rdata
);
    // Capture the request when it is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_kind  <= K_DRD;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            case (req_kind)
                2'd0:    lat_kind <= K_FETCH;
                2'd2:    lat_kind <= K_DWR;
                default: lat_kind <= K_DRD;
            endcase
        end
    end

    // Sample returned data at the edge that ends the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (last_strb && lat_kind != K_DWR)
            rdata <= ad_in;
    end
endmodule

// File: rtl/xbus_csdec.sv
// Chip-select decoder: one active-low select per value of the top
// CS_BITS address bits, all held high when not enabled.
// Assumes: en is high only during an external cycle.
module xbus_csdec #(
    parameter int ADDR_W  = 16,
    parameter int CS_BITS = 3
) (
    input  logic                  en,
    input  logic [ADDR_W-1:0]     addr,
    output logic [2**CS_BITS-1:0] cs_n
);
    localparam int NSEL = 2 ** CS_BITS;
    logic [CS_BITS-1:0] region;
    assign region = addr[ADDR_W-1 -: CS_BITS];

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        // Pull select i low when the region matches
        always_comb cs_n[i] = !(en && region == CS_BITS'(i));
    end
endmodule

// File: rtl/xbus_seq.sv
// External bus sequencer top: drives the multiplexed port, the high
// address, the latch enable, the strobes and the chip selects from the
// current phase and the captured request.
// Assumes: the pad ring merges ad_out/ad_oe/ad_in into one pin set.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int DATA_W         = 8,
    parameter int STROBE_CYCLES  = 2,
    parameter int INT_CODE_BYTES = 4096,
    parameter int CS_BITS        = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     code_int_en,
    output logic                     busy,
    output logic                     done,
    output logic                     int_hit,
    output logic [DATA_W-1:0]        rdata,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] hi_addr,
    output logic                     ale,
    output logic                     fetch_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [2**CS_BITS-1:0]    cs_n
);
    phase_t            phase;
    logic              accept, last_strb, ext, strobe;
    logic [ADDR_W-1:0] lat_addr;
    kind_t             lat_kind;
    logic [DATA_W-1:0] lat_wdata;

    xbus_phase #(
        .ADDR_W(ADDR_W), .STROBE_CYCLES(STROBE_CYCLES),
        .INT_CODE_BYTES(INT_CODE_BYTES)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_kind(req_kind), .req_addr(req_addr),
        .code_int_en(code_int_en), .phase(phase),
        .accept(accept), .last_strb(last_strb)
    );

    xbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .last_strb(last_strb),
        .ad_in(ad_in), .lat_addr(lat_addr), .lat_kind(lat_kind),
        .lat_wdata(lat_wdata), .rdata(rdata)
    );

    xbus_csdec #(.ADDR_W(ADDR_W), .CS_BITS(CS_BITS)) u_cs (
        .en(ext), .addr(lat_addr), .cs_n(cs_n)
    );

    // Derive the bus pins from the phase
    always_comb begin
        ext     = (phase == PH_ADDR) || (phase == PH_SETUP)
                  || (phase == PH_STRB) || (phase == PH_HOLD);
        strobe  = (phase == PH_STRB);
        ale     = (phase == PH_ADDR);
        ad_out  = ale ? lat_addr[DATA_W-1:0] : lat_wdata;
        ad_oe   = ale || (ext && lat_kind == K_DWR);
        hi_addr = lat_addr[ADDR_W-1:DATA_W];
        fetch_n = !(strobe && lat_kind == K_FETCH);
        rd_n    = !(strobe && lat_kind == K_DRD);
        wr_n    = !(strobe && lat_kind == K_DWR);
        done    = (phase == PH_HOLD) || (phase == PH_INT);
        int_hit = (phase == PH_INT);
        busy    = (phase != PH_IDLE);
    end
endmodule

// File: rtl/xbus_seq_chk.sv
// Property checker for the bus sequencer, bound to every instance.
// Assumes: pins observed as driven by xbus_seq.
module xbus_seq_chk #(
    parameter int HI_W  = 8,
    parameter int NSEL  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ale,
    input logic            fetch_n,
    input logic            rd_n,
    input logic            wr_n,
    input logic            ad_oe,
    input logic [HI_W-1:0] hi_addr,
    input logic [NSEL-1:0] cs_n,
    input logic            done,
    input logic            int_hit,
    input logic            busy
);
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!fetch_n, !rd_n, !wr_n}) <= 1);
    p_no_strobe_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (fetch_n && rd_n && wr_n));
    p_addr_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);
    p_rd_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !fetch_n) |-> !ad_oe);
    p_wr_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);
    p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ad_oe);
    p_hi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale && !int_hit && !$past(int_hit)) |-> $stable(hi_addr));
    p_cs_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    p_cs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_int_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_hit |-> (done && !ale && (&cs_n) && fetch_n));
endmodule

bind xbus_seq xbus_seq_chk #(.HI_W(ADDR_W - DATA_W), .NSEL(2 ** CS_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ale(ale), .fetch_n(fetch_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_oe(ad_oe), .hi_addr(hi_addr), .cs_n(cs_n),
    .done(done), .int_hit(int_hit), .busy(busy)
);

// File: tb/xbus_seq_bench.sv
// Scoreboard bench: the driver queues expected items, the bus monitor
// records what each cycle looked like and compares it on done.
module xbus_seq_bench;
    localparam int STRB = 2;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, code_int_en = 0;
    logic [1:0]  req_kind = 0;
    logic [15:0] req_addr = 0;
    logic [7:0]  req_wdata = 0;
    logic        busy, done, int_hit, ad_oe, ale, fetch_n, rd_n, wr_n;
    logic [7:0]  rdata, ad_out, ad_in, hi_addr, cs_n;

    int checks = 0, errors = 0;

    typedef struct {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic        internal;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    xbus_seq u_xbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .code_int_en(code_int_en),
        .busy(busy), .done(done), .int_hit(int_hit), .rdata(rdata),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .hi_addr(hi_addr),
        .ale(ale), .fetch_n(fetch_n), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n)
    );

    // External memory model: latched low byte, answers while a read strobe is low
    logic [7:0] lat_lo = 0;
    assign ad_in = (!rd_n || !fetch_n) ? (lat_lo ^ hi_addr ^ 8'h5A) : 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor state
    int nf = 0, nr = 0, nw = 0, cyc = 0, cs_idx = -1, cs_low = 0;
    bit saw_ale = 0, hi_bad = 0, roe_bad = 0, woe_bad = 0, prev_done = 0;
    logic [7:0] m_lo = 0, m_hi = 0, m_w = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) begin
                lat_lo = ad_out; m_lo = ad_out; m_hi = hi_addr; saw_ale = 1; cyc = 0;
                cs_low = 0;
                for (int i = 0; i < 8; i++) if (!cs_n[i]) begin cs_idx = i; cs_low++; end
            end else if (saw_ale) cyc++;
            if (!fetch_n) nf++;
            if (!rd_n) nr++;
            if (!wr_n) begin nw++; m_w = ad_out; if (!ad_oe) woe_bad = 1; end
            if ((!rd_n || !fetch_n) && ad_oe) roe_bad = 1;
            if (saw_ale && hi_addr != m_hi) hi_bad = 1;
            if (prev_done && done) chk(0, "R7 done pulse width", 2, 1);
            prev_done = done;
            if (done) begin
                exp_t e;
                if (exp_q.size() == 0) chk(0, "R7 unexpected done", 1, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(int_hit == e.internal, "R10/R9 int_hit", int_hit, e.internal);
                    if (e.internal) begin
                        chk(!saw_ale && nf == 0, "R10 no bus activity", nf, 0);
                    end else begin
                        chk(m_lo == e.addr[7:0], "R1 low address", m_lo, e.addr[7:0]);
                        chk(!hi_bad && m_hi == e.addr[15:8], "R3 high address", m_hi, e.addr[15:8]);
                        chk(cs_low == 1 && cs_idx == int'(e.addr[15:13]), "R8 chip select", cs_idx, e.addr[15:13]);
                        chk(cyc == STRB + 2, "R7 done timing", cyc, STRB + 2);
                        case (e.kind)
                            2'd0: chk(nf == STRB && nr == 0 && nw == 0, "R4/R5 fetch strobe", nf, STRB);
                            2'd2: chk(nw == STRB && nr == 0 && nf == 0, "R4/R5 write strobe", nw, STRB);
                            default: chk(nr == STRB && nf == 0 && nw == 0, "R4/R5 read strobe", nr, STRB);
                        endcase
                        if (e.kind == 2'd2) begin
                            chk(!woe_bad && m_w == e.wdata, "R2 write data", m_w, e.wdata);
                            chk(ad_oe && ad_out == e.wdata, "R2 write hold", ad_out, e.wdata);
                        end else begin
                            chk(!roe_bad, "R2 port released", roe_bad, 0);
                            chk(rdata == (e.addr[7:0] ^ e.addr[15:8] ^ 8'h5A), "R6 read data",
                                rdata, e.addr[7:0] ^ e.addr[15:8] ^ 8'h5A);
                        end
                    end
                end
                nf = 0; nr = 0; nw = 0; saw_ale = 0; hi_bad = 0; roe_bad = 0;
                woe_bad = 0; cs_idx = -1; cs_low = 0;
            end
        end
    end

    // Driver: queue the expectation and present one request
    task automatic do_tx(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
        exp_t e;
        e.kind = k; e.addr = a; e.wdata = d;
        e.internal = (k == 2'd0) && code_int_en && (a < 16'h1000);
        exp_q.push_back(e);
        req_valid = 1; req_kind = k; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(!ale && !ad_oe && !done && !int_hit && !busy, "R11 reset controls",
            {ale, ad_oe, done, int_hit, busy}, 0);
        chk(fetch_n && rd_n && wr_n && cs_n == 8'hFF, "R11 reset strobes/selects",
            {fetch_n, rd_n, wr_n, cs_n}, 11'h7FF);
        // R9: external fetches with internal code disabled
        code_int_en = 0;
        do_tx(2'd0, 16'h0000, 8'h00);
        do_tx(2'd0, 16'h0123, 8'h00);
        // Reads and writes across regions
        do_tx(2'd1, 16'h3456, 8'h00);
        do_tx(2'd2, 16'h8A5C, 8'hC3);
        do_tx(2'd1, 16'hFFFF, 8'h00);
        do_tx(2'd2, 16'h2001, 8'h3C);
        do_tx(2'd3, 16'h6E10, 8'h00);
        // R10: internal boundary
        code_int_en = 1;
        do_tx(2'd0, 16'h0FFF, 8'h00);
        do_tx(2'd0, 16'h1000, 8'h00);
        do_tx(2'd0, 16'h0010, 8'h00);
        do_tx(2'd1, 16'h0010, 8'h00);
        do_tx(2'd0, 16'hE7B2, 8'h00);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 every request completed", exp_q.size(), 0);
        summary();
    end
endmodule